// File: doc/BRIEF.md
# Four-Channel PWM Register Front End

This block sits between a simple 32-bit register bus and four PWM channel cores. It owns the global run state of the channels. A write-one-to-start register and a write-one-to-stop register change that state. A read-only run-status register shows it. A per-channel end-of-period flag register clears itself when it is read. Any access that falls inside the strided per-channel window is passed through to the matching channel core. The waveform counters themselves live in the channel cores. Each core reports a one-cycle end-of-period pulse back to this block.

Software starts a channel by writing a 1 to the start register in that channel's bit position. It stops the channel the same way through the stop register. It polls the flag register to learn which channels have finished a period since the last poll. All reads are registered: the data for a read issued in one cycle appears on `rdata` after the next rising edge.

Top module: `pwmctl_regfront`

## Requirements
- R1: After a synchronous reset, every run bit (`run_en`), every end-of-period flag, `rdata` and all channel strobes are zero.
- R2: A write to offset 0x004 sets run bit n for every bit n of `wdata[3:0]` that is 1. Zero bits and bits 31:4 leave the run bits unchanged. The new state is visible one clock after the write.
- R3: A write to offset 0x008 clears run bit n for every bit n of `wdata[3:0]` that is 1. Zero bits leave the run bits unchanged.
- R4: A read of offset 0x00C returns the run bits in `rdata[3:0]` with bits 31:4 zero, so 0x0000000F means all four channels run.
- R5: A pulse on `period_end[n]` sets flag n. A read of offset 0x01C returns the flags in bits 3:0.
- R6: A read of offset 0x01C clears every flag that was set before that read.
- R7: A `period_end` pulse in the same cycle as a read of 0x01C is not reported by that read, and its flag stays set for the next read.
- R8: Offsets 0x200 + n*0x20 through 0x21F + n*0x20 (n = 0..3) belong to channel n. A write there asserts only `ch_we[n]`, with `ch_off` = addr[4:0] and `ch_wdata` = `wdata`, in the same cycle. A read asserts only `ch_re[n]`.
- R9: A read in channel n's window returns the value on `ch_rdata[32n+31:32n]` in that cycle, on `rdata` one clock later.
- R10: A read of any unmapped offset (for example 0x010 or 0x280) returns zero. A write to an unmapped or read-only offset changes no run bit and asserts no channel strobe. `rdata` is zero after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 10 | Byte offset of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| period_end | input | 4 | End-of-period pulses from the channel cores |
| run_en | output | 4 | Run enable for each channel core |
| ch_we | output | 4 | One-hot write strobe into the channel window |
| ch_re | output | 4 | One-hot read strobe into the channel window |
| ch_off | output | 5 | Offset within the channel window |
| ch_wdata | output | 32 | Write data passed to the channel |
| ch_rdata | input | 128 | Read data from the four channels, channel n at bits 32n+31:32n |

## Verification
Channel strobes, `ch_off` and `ch_wdata` are combinational, so they are checked in the same cycle the access is driven. Run bits and flags change one edge after their write or pulse. Read data appears on the edge that samples `re`. Inputs change on the falling edge. The monitor notes whether `re` was high at a rising edge and compares `rdata` a short delay after that edge against the oldest expected item in the scoreboard queue. A flag read that coincides with a new pulse is followed by a second read, which shows the pulse was kept.

// File: rtl/pwmctl_pkg.sv
package pwmctl_pkg;

    localparam int NUM_CH    = 4;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 32;
    localparam int WIN_W     = 5;                      // 32-byte channel window
    localparam int WIN_BYTES = 1 << WIN_W;

    localparam logic [ADDR_W-1:0] OFS_START = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_STOP  = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_RUN   = 10'h00C;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 10'h01C;
    localparam logic [ADDR_W-1:0] CH_BASE   = 10'h200;
    localparam int                CH_SPAN   = NUM_CH * WIN_BYTES;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_START,
        HIT_STOP,
        HIT_RUN,
        HIT_FLAG,
        HIT_CHAN
    } hit_e;

    typedef struct packed {
        hit_e                hit;
        logic [CH_IDX_W-1:0] ch;
        logic [WIN_W-1:0]    off;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] rel;
        rel   = a - CH_BASE;
        d.hit = HIT_NONE;
        d.ch  = rel[WIN_W +: CH_IDX_W];
        d.off = a[WIN_W-1:0];
        if (a == OFS_START)      d.hit = HIT_START;
        else if (a == OFS_STOP)  d.hit = HIT_STOP;
        else if (a == OFS_RUN)   d.hit = HIT_RUN;
        else if (a == OFS_FLAG)  d.hit = HIT_FLAG;
        else if (a >= CH_BASE && int'(rel) < CH_SPAN) d.hit = HIT_CHAN;
        return d;
    endfunction

endpackage

// File: rtl/pwmctl_decode.sv
module pwmctl_decode
    import pwmctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb dec = decode(addr);
endmodule

// File: rtl/pwmctl_runctl.sv
module pwmctl_runctl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_req,
    input  logic         clr_req,
    input  logic [N-1:0] mask,
    output logic [N-1:0] run_q
);
    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (set_req) run_q <= run_q | mask;
        else if (clr_req) run_q <= run_q & ~mask;
    end
endmodule

// File: rtl/pwmctl_evtflag.sv
module pwmctl_evtflag #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pulse,
    input  logic         rd_clr,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] keep;
    assign keep = rd_clr ? '0 : flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= keep | pulse;   // a pulse always survives a clearing read
    end
endmodule

// File: rtl/pwmctl_regfront.sv
module pwmctl_regfront
    import pwmctl_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            we,
    input  logic            re,
    output logic [DW-1:0]   rdata,
    input  logic [N-1:0]    period_end,
    output logic [N-1:0]    run_en,
    output logic [N-1:0]    ch_we,
    output logic [N-1:0]    ch_re,
    output logic [WIN_W-1:0] ch_off,
    output logic [DW-1:0]   ch_wdata,
    input  logic [N*DW-1:0] ch_rdata
);
    dec_t          dec;
    logic [N-1:0]  run_q;
    logic [N-1:0]  flag_q;
    logic [DW-1:0] rd_mux;

    pwmctl_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    pwmctl_runctl #(.N(N)) u_run (
        .clk     (clk),
        .rst     (rst),
        .set_req (we && dec.hit == HIT_START),
        .clr_req (we && dec.hit == HIT_STOP),
        .mask    (wdata[N-1:0]),
        .run_q   (run_q)
    );

    pwmctl_evtflag #(.N(N)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .pulse  (period_end),
        .rd_clr (re && dec.hit == HIT_FLAG),
        .flag_q (flag_q)
    );

    assign run_en   = run_q;
    assign ch_off   = dec.off;
    assign ch_wdata = wdata;

    for (genvar n = 0; n < N; n++) begin : g_chsel
        logic hit_n;
        assign hit_n    = (dec.hit == HIT_CHAN) && (int'(dec.ch) == n);
        assign ch_we[n] = we && hit_n;
        assign ch_re[n] = re && hit_n;
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.hit)
            HIT_RUN:  rd_mux[N-1:0] = run_q;
            HIT_FLAG: rd_mux[N-1:0] = flag_q;
            HIT_CHAN: rd_mux = ch_rdata[int'(dec.ch)*DW +: DW];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= rd_mux;
        else         rdata <= '0;
    end
endmodule

// File: rtl/pwmctl_regfront_chk.sv
module pwmctl_regfront_chk
    import pwmctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              we,
    input logic              re,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] period_end,
    input logic [NUM_CH-1:0] run_en,
    input logic [NUM_CH-1:0] flag_q,
    input logic [NUM_CH-1:0] ch_we,
    input logic [NUM_CH-1:0] ch_re
);
    p_start_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_START) |=> ((run_en & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

    p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_STOP) |=> ((run_en & $past(wdata[NUM_CH-1:0])) == '0));

    p_run_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(we && (addr == OFS_START || addr == OFS_STOP)) |=> $stable(run_en));

    p_pulse_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (period_end != '0) |=> ((flag_q & $past(period_end)) == $past(period_end)));

    p_chwe_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_we) && $onehot0(ch_re));

    p_chwe_needs_we_r8: assert property (@(posedge clk) disable iff (rst)
        (ch_we != '0) |-> we);

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !re |=> (rdata == '0));
endmodule

bind pwmctl_regfront pwmctl_regfront_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wdata      (wdata),
    .we         (we),
    .re         (re),
    .rdata      (rdata),
    .period_end (period_end),
    .run_en     (run_en),
    .flag_q     (flag_q),
    .ch_we      (ch_we),
    .ch_re      (ch_re)
);

// File: tb/pwmctl_regfront_tb.sv
module pwmctl_regfront_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  period_end = '0;
    logic [3:0]  run_en;
    logic [3:0]  ch_we;
    logic [3:0]  ch_re;
    logic [4:0]  ch_off;
    logic [31:0] ch_wdata;
    logic [127:0] ch_rdata;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    always_comb begin
        for (int n = 0; n < 4; n++)
            ch_rdata[n*32 +: 32] = 32'hC0DE0000 | (32'(n) << 8) | 32'(ch_off);
    end

    pwmctl_regfront u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata), .period_end(period_end), .run_en(run_en),
        .ch_we(ch_we), .ch_re(ch_re), .ch_off(ch_off), .ch_wdata(ch_wdata),
        .ch_rdata(ch_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(logic w, logic r, logic [9:0] a, logic [31:0] d, logic [3:0] pe);
        @(negedge clk);
        we = w; re = r; addr = a; wdata = d; period_end = pe;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 10'h000, 32'h0, 4'h0);
    endtask

    task automatic rd(logic [9:0] a, logic [31:0] exp, string tag, logic [3:0] pe = 4'h0);
        bus(1'b0, 1'b1, a, 32'h0, pe);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: compare rdata after each edge that sampled a read
    initial begin
        forever begin
            logic was_rd;
            @(posedge clk);
            was_rd = re && !rst;
            #2;
            if (was_rd) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard", 32'h1, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 run_en", 32'(run_en), 32'h0);
        check("R1 rdata", rdata, 32'h0);
        check("R1 ch_we", 32'(ch_we), 32'h0);
        @(negedge clk); rst = 1'b0;
        rd(10'h01C, 32'h0, "R1 flags");

        // R2 start register
        bus(1'b1, 1'b0, 10'h004, 32'h5, 4'h0); idle(); #1;
        check("R2 set 0101", 32'(run_en), 32'h5);
        bus(1'b1, 1'b0, 10'h004, 32'h2, 4'h0); idle(); #1;
        check("R2 zeros keep", 32'(run_en), 32'h7);
        bus(1'b1, 1'b0, 10'h004, 32'hFFFFFFF0, 4'h0); idle(); #1;
        check("R2 upper bits", 32'(run_en), 32'h7);

        // R4 run status read
        rd(10'h00C, 32'h7, "R4 status 7");
        bus(1'b1, 1'b0, 10'h004, 32'h8, 4'h0);
        rd(10'h00C, 32'hF, "R4 all on");

        // R3 stop register
        bus(1'b1, 1'b0, 10'h008, 32'h5, 4'h0); idle(); #1;
        check("R3 clear 0101", 32'(run_en), 32'hA);
        bus(1'b1, 1'b0, 10'h008, 32'h0, 4'h0); idle(); #1;
        check("R3 zeros keep", 32'(run_en), 32'hA);
        rd(10'h00C, 32'hA, "R4 status A");

        // R5 / R6 flags
        bus(1'b0, 1'b0, 10'h000, 32'h0, 4'h3); idle();
        rd(10'h01C, 32'h3, "R5 flags 3");
        rd(10'h01C, 32'h0, "R6 cleared");

        // R7 pulse coincident with clearing read
        bus(1'b0, 1'b0, 10'h000, 32'h0, 4'h4);
        rd(10'h01C, 32'h4, "R7 old flag", 4'h8);
        rd(10'h01C, 32'h8, "R7 kept pulse");
        rd(10'h01C, 32'h0, "R6 cleared again");

        // R8 channel window write
        bus(1'b1, 1'b0, 10'h24C, 32'hABCD1234, 4'h0); #1;
        check("R8 ch_we", 32'(ch_we), 32'h4);
        check("R8 ch_off", 32'(ch_off), 32'h0C);
        check("R8 ch_wdata", ch_wdata, 32'hABCD1234);
        bus(1'b1, 1'b0, 10'h21F, 32'h1, 4'h0); #1;
        check("R8 ch0 top", 32'(ch_we), 32'h1);

        // R9 channel window read
        rd(10'h26C, 32'hC0DE030C, "R9 ch3 read"); #1;
        check("R8 ch_re", 32'(ch_re), 32'h8);
        rd(10'h220, 32'hC0DE0100, "R9 ch1 read");

        // R10 unmapped
        rd(10'h010, 32'h0, "R10 read 0x010");
        rd(10'h280, 32'h0, "R10 read 0x280");
        bus(1'b1, 1'b0, 10'h280, 32'hF, 4'h0); #1;
        check("R10 no ch_we", 32'(ch_we), 32'h0);
        bus(1'b1, 1'b0, 10'h00C, 32'hF, 4'h0); idle(); #1;
        check("R10 run unchanged", 32'(run_en), 32'hA);
        check("R10 idle rdata", rdata, 32'h0);

        idle(); idle();
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule